// File: doc/BRIEF.md
# Dual-Compare Programmable Interval Timer

A 16-bit interval timer channel controlled through a small register interface. Software loads two terminal-count values (A and B), sets up a control word and enables the channel. The counter then advances by one on each internal timing strobe, but only while a level-sensitive gate input is high. When the next count would equal the active terminal value, the counter returns to zero, a sticky done flag sets and a one-cycle pulse goes out.

In single mode only terminal value A is used. In dual mode the channel alternates between A and B, and a read-only control bit reports which value is active. A one-shot run turns the enable bit off at the end of its sequence. In dual mode a sequence covers both the A phase and the B phase. A continuous run repeats without stopping. The terminal test is an equality test, so a count that starts above the terminal value runs up through 0xFFFF and wraps to zero before it can terminate. A terminal value of zero therefore gives a period of 65536 strobes.

The register interface has no handshake. A write takes effect at the clock edge where the write strobe is high, and read data is a combinational function of the address.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, the count register, both terminal registers and the control word all read 0, and `maxcount_pulse` is low.
- R2: Address map: 0 is the count, 1 is terminal A, 2 is terminal B, 3 is the control word. `rdata` reflects the addressed register in the same cycle. Control bits are: 0 enable, 1 continuous, 2 dual, 3 B-active (read-only), 4 done, 5 external-clock select, 6 retrigger select.
- R3: On an advancing cycle where the count plus one equals the active terminal value (16-bit wrap), the count becomes 0 and `maxcount_pulse` is high for exactly the cycle in which the count reads 0. A terminal value of 1 terminates on every advance. A terminal value of 0 terminates after the count passes 0xFFFF.
- R4: Only equality ends a period. A count above the terminal value keeps incrementing, passes through 0xFFFF to 0 without a pulse, and terminates when it next reaches the terminal value.
- R5: The done bit sets on every terminal count and hardware never clears it. A control write with bit 4 at 0 clears it. A control write with bit 4 at 1 leaves it as it was.
- R6: The count advances by one only on a clock edge where `count_tick`, `gate_in` and the enable bit are all high. With the gate low, ticks are ignored, and no rising edge of the gate is needed.
- R7: With the dual bit clear, only terminal A is used and the B-active bit reads 0.
- R8: With the dual bit set, periods alternate A, B, A, ... The B-active bit reads 1 while terminal B is in use.
- R9: With the continuous bit clear, the enable bit clears itself at the terminal count that ends the sequence: the A terminal in single mode, the B terminal in dual mode. After that, further ticks leave the count unchanged. With the continuous bit set, the enable bit stays set.
- R10: A control write that changes the enable bit from 0 to 1 makes terminal A active.
- R11: A write to the count register loads it only while the enable bit is 0. While the enable bit is 1, such a write has no effect.
- R12: While the external-clock bit or the retrigger bit is set, ticks do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Combinational read data for `addr` |
| count_tick | input | 1 | One-cycle internal timing strobe |
| gate_in | input | 1 | Level-sensitive count enable |
| maxcount_pulse | output | 1 | One-cycle pulse at each terminal count |

## Verification
A tick applied before a clock edge shows up in the count, in `maxcount_pulse` and in the done, enable and B-active bits right after that edge, because every result passes through exactly one register. Register writes follow the same single-edge rule, and reads need no edge at all. The bench therefore drives stimulus on the falling edge and samples one time step after the next rising edge. It reads registers combinationally at a falling edge, after the write cycle has completed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // register slots
  localparam logic [1:0] A_COUNT = 2'd0;
  localparam logic [1:0] A_CMPA  = 2'd1;
  localparam logic [1:0] A_CMPB  = 2'd2;
  localparam logic [1:0] A_CTRL  = 2'd3;

  // control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_CONT = 1;
  localparam int CB_DUAL = 2;
  localparam int CB_SELB = 3;
  localparam int CB_DONE = 4;
  localparam int CB_EXT  = 5;
  localparam int CB_RTG  = 6;
  localparam int CTRL_W  = 7;

  typedef struct packed {
    logic rtg;
    logic ext;
    logic done;
    logic selb;
    logic dual;
    logic cont;
    logic en;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         sel_b,
  output logic [W-1:0] cmp_a,
  output logic [W-1:0] cmp_b,
  output logic [W-1:0] cmp_active
);
  import tmr_pkg::*;
  localparam int NCMP = 2;

  logic [NCMP-1:0][W-1:0] cmp_q;

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    localparam logic [1:0] SLOT = 2'(int'(A_CMPA) + i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cmp_q[i] <= '0;
      else if (wr_en && addr == SLOT)   cmp_q[i] <= wdata;
    end
  end

  assign cmp_a      = cmp_q[0];
  assign cmp_b      = cmp_q[1];
  assign cmp_active = sel_b ? cmp_q[1] : cmp_q[0];
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp_active,
  output logic [W-1:0] count,
  output logic         hit,
  output logic         pulse
);
  logic [W-1:0] count_q;
  logic [W-1:0] nxt;
  logic         pulse_q;

  assign nxt = count_q + W'(1);
  assign hit = adv && (nxt == cmp_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit;
      if (load)      count_q <= load_val;
      else if (hit)  count_q <= '0;
      else if (adv)  count_q <= nxt;
    end
  end

  assign count = count_q;
  assign pulse = pulse_q;

  // R3: the pulse coincides with the count reading zero
  a_r3_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (count_q == '0));

  // R6: without an advance or a load the count holds
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(count_q));
endmodule

// File: rtl/tmr_seq_ctrl.sv
module tmr_seq_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              hit,
  output tmr_ctrl_t         ctrl
);
  tmr_ctrl_t q;
  logic      seq_end;
  logic      en_rise;

  assign seq_end = !q.dual || q.selb;
  assign en_rise = ctrl_wdata[CB_EN] && !q.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (ctrl_wr) begin
      q.en   <= ctrl_wdata[CB_EN];
      q.cont <= ctrl_wdata[CB_CONT];
      q.dual <= ctrl_wdata[CB_DUAL];
      q.ext  <= ctrl_wdata[CB_EXT];
      q.rtg  <= ctrl_wdata[CB_RTG];
      q.done <= (q.done && ctrl_wdata[CB_DONE]) || hit;
      if (en_rise || !ctrl_wdata[CB_DUAL]) q.selb <= 1'b0;
    end else if (hit) begin
      q.done <= 1'b1;
      if (q.dual)               q.selb <= !q.selb;
      if (seq_end && !q.cont)   q.en   <= 1'b0;
    end
  end

  assign ctrl = q;

  // R5: a terminal count always leaves the done flag set
  a_r5_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> q.done);

  // R7: single mode never selects terminal B
  a_r7_single_uses_a: assert property (@(posedge clk) disable iff (!rst_n)
    !q.dual |-> !q.selb);

  // R9: one-shot stops at the end of its sequence
  a_r9_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !q.cont && seq_end && !ctrl_wr) |=> !q.en);

  // R10: enabling restarts on terminal A
  a_r10_enable_selects_a: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && en_rise) |=> !q.selb);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             count_tick,
  input  logic             gate_in,
  output logic             maxcount_pulse
);
  import tmr_pkg::*;

  tmr_ctrl_t        ctrl;
  logic [CNT_W-1:0] cmp_a, cmp_b, cmp_active, count;
  logic             adv, load, hit, ctrl_wr;

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign load    = wr_en && (addr == A_COUNT) && !ctrl.en;
  assign adv     = ctrl.en && count_tick && gate_in && !ctrl.ext && !ctrl.rtg;

  tmr_cmp_bank #(.W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sel_b(ctrl.selb), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_active(cmp_active)
  );

  tmr_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(load), .load_val(wdata),
    .cmp_active(cmp_active), .count(count), .hit(hit), .pulse(maxcount_pulse)
  );

  tmr_seq_ctrl u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(wdata[CTRL_W-1:0]), .hit(hit), .ctrl(ctrl)
  );

  always_comb begin
    case (addr)
      A_COUNT: rdata = count;
      A_CMPA:  rdata = cmp_a;
      A_CMPB:  rdata = cmp_b;
      default: rdata = CNT_W'(ctrl);
    endcase
  end

  // R6: a pulse can only follow a gated tick
  a_r6_pulse_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    maxcount_pulse |-> $past(count_tick && gate_in));

  // R12: external or retrigger selection freezes the count
  a_r12_ext_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl.ext || ctrl.rtg) && !load) |=> $stable(count));

  // R11: writes to the count while enabled are dropped
  a_r11_no_load_running: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_COUNT && ctrl.en && !adv) |=> $stable(count));
endmodule

// File: tb/test_dual_cmp_timer.sv
module test_dual_cmp_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        count_tick = 1'b0;
  logic        gate_in = 1'b0;
  logic        maxcount_pulse;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_cmp_timer i_dual_cmp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .count_tick(count_tick), .gate_in(gate_in),
    .maxcount_pulse(maxcount_pulse)
  );

  // {tick, gate, pulse, count}; terminal A=3, B=2, dual continuous
  localparam logic [18:0] VEC [9] = '{
    {1'b1, 1'b1, 1'b0, 16'h0001},
    {1'b0, 1'b1, 1'b0, 16'h0001},
    {1'b1, 1'b0, 1'b0, 16'h0001},
    {1'b1, 1'b1, 1'b0, 16'h0002},
    {1'b1, 1'b1, 1'b1, 16'h0000},
    {1'b1, 1'b1, 1'b0, 16'h0001},
    {1'b1, 1'b1, 1'b1, 16'h0000},
    {1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b1, 1'b1, 1'b0, 16'h0001}
  };

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string req);
    addr = a;
    #1;
    chk(rdata == exp, req, rdata, exp);
  endtask

  task automatic step(input logic t, input logic g, input logic [15:0] ec, input logic ep, input string req);
    @(negedge clk);
    addr = 2'd0; count_tick = t; gate_in = g;
    @(posedge clk);
    #1;
    count_tick = 1'b0;
    chk(rdata == ec, {req, " count"}, rdata, ec);
    chk(maxcount_pulse == ep, {req, " pulse"}, 16'(maxcount_pulse), 16'(ep));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    // R1 reset state, R2 map
    rd(2'd0, 16'h0000, "R1 count");
    rd(2'd1, 16'h0000, "R1 cmpA");
    rd(2'd2, 16'h0000, "R1 cmpB");
    rd(2'd3, 16'h0000, "R1 ctrl");
    chk(maxcount_pulse == 1'b0, "R1 pulse", 16'(maxcount_pulse), 16'h0);
    @(negedge clk); rst_n = 1'b1;

    wr(2'd1, 16'h0003);
    wr(2'd2, 16'h0002);
    rd(2'd1, 16'h0003, "R2 cmpA readback");
    rd(2'd2, 16'h0002, "R2 cmpB readback");
    wr(2'd3, 16'h0007);

    // vector walk: R6 gate/tick, R3 terminal, R8 alternation
    foreach (VEC[i]) step(VEC[i][18], VEC[i][17], VEC[i][15:0], VEC[i][16], "R8 vector");

    // R5 done flag sticky
    rd(2'd3, 16'h0017, "R5 done set");
    wr(2'd3, 16'h0017);
    rd(2'd3, 16'h0017, "R5 write one keeps");
    wr(2'd3, 16'h0007);
    rd(2'd3, 16'h0007, "R5 write zero clears");

    // R11 count write ignored while enabled
    wr(2'd0, 16'h0055);
    rd(2'd0, 16'h0001, "R11 ignored");

    // R10 enable restarts on A
    wr(2'd3, 16'h0006);
    wr(2'd0, 16'h0000);
    rd(2'd0, 16'h0000, "R11 load while disabled");
    wr(2'd3, 16'h0007);
    step(1, 1, 16'h0001, 0, "R10");
    step(1, 1, 16'h0002, 0, "R10");
    step(1, 1, 16'h0000, 1, "R10");
    wr(2'd3, 16'h0006);
    rd(2'd3, 16'h000E, "R8 B active");
    wr(2'd3, 16'h0007);
    rd(2'd3, 16'h0007, "R10 back to A");

    // R9 one-shot single
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0002);
    wr(2'd3, 16'h0001);
    step(1, 1, 16'h0001, 0, "R9 single");
    step(1, 1, 16'h0000, 1, "R9 single");
    rd(2'd3, 16'h0010, "R9 single stopped");
    step(1, 1, 16'h0000, 0, "R9 idle after stop");

    // R9/R8 one-shot dual
    wr(2'd1, 16'h0001);
    wr(2'd2, 16'h0002);
    wr(2'd3, 16'h0005);
    step(1, 1, 16'h0000, 1, "R8 dual A");
    rd(2'd3, 16'h001D, "R8 dual now B");
    step(1, 1, 16'h0001, 0, "R8 dual B");
    step(1, 1, 16'h0000, 1, "R8 dual B");
    rd(2'd3, 16'h0014, "R9 dual stopped");

    // R7 single continuous
    wr(2'd1, 16'h0002);
    wr(2'd3, 16'h0003);
    step(1, 1, 16'h0001, 0, "R7");
    step(1, 1, 16'h0000, 1, "R7");
    rd(2'd3, 16'h0013, "R7 A only");
    step(1, 1, 16'h0001, 0, "R7");
    step(1, 1, 16'h0000, 1, "R7");
    rd(2'd3, 16'h0013, "R9 continuous runs");

    // R12 ext / retrigger freeze
    wr(2'd3, 16'h0023);
    step(1, 1, 16'h0000, 0, "R12 ext");
    wr(2'd3, 16'h0043);
    step(1, 1, 16'h0000, 0, "R12 rtg");
    wr(2'd3, 16'h0003);
    step(1, 1, 16'h0001, 0, "R12 resume");

    // R3 terminal zero = 65536
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'hFFFE);
    wr(2'd1, 16'h0000);
    wr(2'd3, 16'h0003);
    step(1, 1, 16'hFFFF, 0, "R3 zero");
    step(1, 1, 16'h0000, 1, "R3 zero");

    // R4 equality only, wrap
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'hFFFC);
    wr(2'd1, 16'h0003);
    wr(2'd3, 16'h0003);
    step(1, 1, 16'hFFFD, 0, "R4");
    step(1, 1, 16'hFFFE, 0, "R4");
    step(1, 1, 16'hFFFF, 0, "R4");
    step(1, 1, 16'h0000, 0, "R4 wrap no pulse");
    step(1, 1, 16'h0001, 0, "R4");
    step(1, 1, 16'h0002, 0, "R4");
    step(1, 1, 16'h0000, 1, "R4 terminal");

    // R3 terminal one
    wr(2'd3, 16'h0000);
    wr(2'd1, 16'h0001);
    wr(2'd3, 16'h0003);
    step(1, 1, 16'h0000, 1, "R3 one");
    step(1, 1, 16'h0000, 1, "R3 one");
    step(1, 0, 16'h0000, 0, "R6 gate low");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule